// File: doc/BRIEF.md
# DCC-Commanded DC Motor PWM Driver

This block drives a plain DC locomotive from the same command bytes a digital track controller would send to a decoder-equipped engine. It owns one fixed short address. It watches a small command buffer and turns basic speed commands into a fixed-frequency pulse-width drive. It also turns the direction bits of both the basic and the extended speed commands into a direction level. Time advances only on a 200 ns tick enable. Each drive period is a high phase followed by a low phase, and the default period is 357 ticks, about 14 kHz.

The buffer is not read continuously. The block counts completed low phases. After a set number of them it samples the buffer once, and in that cycle it pulses both a 10 ms tick and a clear-to-send strobe, so the producer may load the next command. A new duty value is taken up only when a new period begins, so a phase is never cut short. Removing track power zeroes the duty at the next period boundary. From then on, every period is entirely low.

Top module: `dccpwm_top`

## Requirements
- R1: After reset, `pwm_out` is at its inactive level, `dir_out` shows reverse, the stored duty is zero, and `tick10` and `cts` are low.
- R2: The phase counters advance only in cycles where `tick` is high. A period with a nonzero high time H lasts exactly PERIOD ticks: H ticks active, then PERIOD-H ticks inactive.
- R3: While the applied high time is zero, every period is PERIOD ticks of the inactive level.
- R4: At the end of every FRAME_PERIODS-th low phase the buffer is sampled. In the next cycle, `tick10` and `cts` are both high for exactly one clock.
- R5: A buffer whose first byte differs from ADDR (default 3) leaves duty and direction unchanged.
- R6: A second byte of the form 01DCSSSS with length of at least 2 is a speed command. SSSS is bits 3..0 and C is bit 4. SSSS of 0 or 1 gives zero duty. Otherwise j = ({SSSS,C} − 3), capped at 28, and the high time is PERIOD/2 + j·(PERIOD/56) ticks, using integer division. The low time is PERIOD minus the high time.
- R7: In a speed command, bit 5 (D) gives the direction: 1 means forward and 0 means reverse.
- R8: A second byte equal to 0x3F with length of at least 3 sets the direction from bit 7 of the third byte (1 means forward). It leaves the duty unchanged. With a length below 3 it is ignored.
- R9: Any other second byte, and any buffer with length below 2, leaves duty and direction unchanged.
- R10: A duty decoded at a sample applies from the period that starts in that same cycle. Within a period the high time never changes.
- R11: With `track_pwr` low at a period boundary, the stored duty is cleared and that period is entirely inactive. When power returns, the duty stays zero until the next sample decodes a speed.
- R12: `pwm_out` is high when active if PWM_ACT_HIGH is 1. `dir_out` is high for forward if DIR_FWD_HIGH is 1, and low for forward if it is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | 200 ns time-base enable |
| track_pwr | input | 1 | Track power on |
| cmd_b0 | input | 8 | Command byte 0 (address) |
| cmd_b1 | input | 8 | Command byte 1 (instruction) |
| cmd_b2 | input | 8 | Command byte 2 (extended data) |
| cmd_len | input | LEN_W | Number of valid command bytes |
| pwm_out | output | 1 | Motor drive |
| dir_out | output | 1 | Direction level |
| tick10 | output | 1 | Frame tick strobe |
| cts | output | 1 | Clear-to-send strobe |

## Verification
The bench keeps PERIOD at 357, so every measured high and low count can be compared with the real speed formula. It lowers FRAME_PERIODS to 2, which lets all 64 speed-byte patterns, the ignored commands and the power cases fit in a short run. It builds DIR_FWD_HIGH as 0, so the inverted direction polarity is exercised. A stretch with `tick` at half rate shows that every phase length scales with the enable and not with the clock.

// File: rtl/dccpwm_pkg.sv
package dccpwm_pkg;
    typedef enum logic {
        PH_LOW  = 1'b0,
        PH_HIGH = 1'b1
    } phase_e;
endpackage

// File: rtl/dccpwm_decode.sv
module dccpwm_decode #(
    parameter int PERIOD = 357,
    parameter int ADDR   = 3,
    parameter int LEN_W  = 3,
    localparam int CNT_W = $clog2(PERIOD + 1)
) (
    input  logic [7:0]       b0,
    input  logic [7:0]       b1,
    input  logic [7:0]       b2,
    input  logic [LEN_W-1:0] len,
    output logic             spd_hit,
    output logic [CNT_W-1:0] spd_hi,
    output logic             dir_hit,
    output logic             dir_fwd
);
    localparam int HALF   = PERIOD / 2;
    localparam int STEP   = PERIOD / 56;
    localparam int JMAX   = 28;

    logic       addr_ok;
    logic       basic;
    logic       adv;
    logic [4:0] code5;
    logic [4:0] j_raw;
    logic [4:0] j_cap;
    int         hi_calc;

    always_comb begin
        addr_ok = (b0 == 8'(ADDR));
        basic   = addr_ok && (int'(len) >= 2) && (b1[7:6] == 2'b01);
        adv     = addr_ok && (int'(len) >= 3) && (b1 == 8'h3F);
        code5   = {b1[3:0], b1[4]};
        j_raw   = code5 - 5'd3;
        j_cap   = (int'(j_raw) > JMAX) ? 5'(JMAX) : j_raw;
        hi_calc = HALF + int'(j_cap) * STEP;
        spd_hit = basic;
        spd_hi  = (b1[3:0] <= 4'd1) ? '0 : CNT_W'(hi_calc);
        dir_hit = basic || adv;
        dir_fwd = basic ? b1[5] : b2[7];
    end

    // p_duty_in_range_r6: a decoded high time always leaves a low phase
    always_comb begin
        if (spd_hit === 1'b1) begin
            p_duty_in_range_r6: assert (int'(spd_hi) < PERIOD);
        end
    end
endmodule

// File: rtl/dccpwm_cmd_reg.sv
module dccpwm_cmd_reg #(
    parameter int PERIOD = 357,
    localparam int CNT_W = $clog2(PERIOD + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sample,
    input  logic             per_start,
    input  logic             pwr,
    input  logic             spd_hit,
    input  logic [CNT_W-1:0] spd_hi,
    input  logic             dir_hit,
    input  logic             dir_fwd,
    output logic [CNT_W-1:0] duty_nxt,
    output logic             fwd_q
);
    typedef struct packed {
        logic [CNT_W-1:0] duty;
        logic             fwd;
    } cmd_t;

    cmd_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (sample && spd_hit) st_d.duty = spd_hi;
        if (sample && dir_hit) st_d.fwd  = dir_fwd;
        if (per_start && !pwr) st_d.duty = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign duty_nxt = st_d.duty;
    assign fwd_q    = st_q.fwd;

    p_cmd_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!sample && !(per_start && !pwr)) |=> $stable(st_q));

    p_pwr_off_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (per_start && !pwr) |=> (st_q.duty == '0));
endmodule

// File: rtl/dccpwm_phase_gen.sv
module dccpwm_phase_gen
    import dccpwm_pkg::*;
#(
    parameter int PERIOD = 357,
    localparam int CNT_W = $clog2(PERIOD + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic [CNT_W-1:0] duty_nxt,
    output logic             low_done,
    output logic             high_phase
);
    typedef struct packed {
        phase_e           phase;
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] hi_lat;
    } ph_t;

    ph_t st_d, st_q;
    logic [CNT_W-1:0] lo_len;
    logic             lo_end;
    logic             hi_end;

    always_comb begin
        st_d   = st_q;
        lo_len = CNT_W'(PERIOD) - st_q.hi_lat;
        hi_end = (st_q.phase == PH_HIGH) && (st_q.cnt == st_q.hi_lat - 1'b1);
        lo_end = (st_q.phase == PH_LOW)  && (st_q.cnt == lo_len - 1'b1);
        if (tick) begin
            if (hi_end) begin
                st_d.phase = PH_LOW;
                st_d.cnt   = '0;
            end else if (lo_end) begin
                st_d.hi_lat = duty_nxt;
                st_d.phase  = (duty_nxt != '0) ? PH_HIGH : PH_LOW;
                st_d.cnt    = '0;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{phase: PH_LOW, cnt: '0, hi_lat: '0};
        else        st_q <= st_d;
    end

    assign low_done   = tick && lo_end;
    assign high_phase = (st_q.phase == PH_HIGH);

    p_hold_no_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(st_q));

    p_hi_fixed_in_period_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !low_done |=> $stable(st_q.hi_lat));

    p_zero_duty_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (low_done && duty_nxt == '0) |=> (st_q.phase == PH_LOW));
endmodule

// File: rtl/dccpwm_frame_cnt.sv
module dccpwm_frame_cnt #(
    parameter int FRAME_PERIODS = 140,
    localparam int FC_W = $clog2(FRAME_PERIODS + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic low_done,
    output logic sample
);
    logic [FC_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d  = cnt_q;
        sample = low_done && (cnt_q == FC_W'(FRAME_PERIODS - 1));
        if (low_done) cnt_d = sample ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    p_cnt_bounded_r4: assert property (@(posedge clk) disable iff (!rst_n)
        int'(cnt_q) < FRAME_PERIODS);
endmodule

// File: rtl/dccpwm_top.sv
module dccpwm_top #(
    parameter int PERIOD        = 357,
    parameter int FRAME_PERIODS = 140,
    parameter int ADDR          = 3,
    parameter int LEN_W         = 3,
    parameter bit PWM_ACT_HIGH  = 1'b1,
    parameter bit DIR_FWD_HIGH  = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             track_pwr,
    input  logic [7:0]       cmd_b0,
    input  logic [7:0]       cmd_b1,
    input  logic [7:0]       cmd_b2,
    input  logic [LEN_W-1:0] cmd_len,
    output logic             pwm_out,
    output logic             dir_out,
    output logic             tick10,
    output logic             cts
);
    localparam int CNT_W = $clog2(PERIOD + 1);

    logic             spd_hit, dir_hit, dir_fwd;
    logic [CNT_W-1:0] spd_hi, duty_nxt;
    logic             low_done, high_phase, sample, fwd_q;

    typedef struct packed {
        logic tick10;
        logic cts;
    } out_t;
    out_t o_d, o_q;

    dccpwm_decode #(.PERIOD(PERIOD), .ADDR(ADDR), .LEN_W(LEN_W)) u_dec (
        .b0(cmd_b0), .b1(cmd_b1), .b2(cmd_b2), .len(cmd_len),
        .spd_hit(spd_hit), .spd_hi(spd_hi), .dir_hit(dir_hit), .dir_fwd(dir_fwd)
    );

    dccpwm_cmd_reg #(.PERIOD(PERIOD)) u_cmd (
        .clk(clk), .rst_n(rst_n), .sample(sample), .per_start(low_done),
        .pwr(track_pwr), .spd_hit(spd_hit), .spd_hi(spd_hi),
        .dir_hit(dir_hit), .dir_fwd(dir_fwd), .duty_nxt(duty_nxt), .fwd_q(fwd_q)
    );

    dccpwm_phase_gen #(.PERIOD(PERIOD)) u_ph (
        .clk(clk), .rst_n(rst_n), .tick(tick), .duty_nxt(duty_nxt),
        .low_done(low_done), .high_phase(high_phase)
    );

    dccpwm_frame_cnt #(.FRAME_PERIODS(FRAME_PERIODS)) u_frm (
        .clk(clk), .rst_n(rst_n), .low_done(low_done), .sample(sample)
    );

    always_comb begin
        o_d.tick10 = sample;
        o_d.cts    = sample;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) o_q <= '0;
        else        o_q <= o_d;
    end

    assign tick10  = o_q.tick10;
    assign cts     = o_q.cts;
    assign pwm_out = PWM_ACT_HIGH ? high_phase : !high_phase;
    assign dir_out = DIR_FWD_HIGH ? fwd_q : !fwd_q;

    p_sample_at_boundary_r4: assert property (@(posedge clk) disable iff (!rst_n)
        sample |-> low_done);

    p_strobe_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        sample |=> (tick10 && cts));

    p_pwr_off_inactive_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (low_done && !track_pwr) |=> (pwm_out == !PWM_ACT_HIGH));

    p_dir_only_on_sample_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !sample |=> $stable(dir_out));
endmodule

// File: tb/sim_dccpwm_top.sv
module sim_dccpwm_top;
    localparam int P  = 357;
    localparam int FP = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b1;
    logic       half_rate = 1'b0;
    logic       track_pwr = 1'b1;
    logic [7:0] cmd_b0 = 8'hFF, cmd_b1 = 8'h00, cmd_b2 = 8'hFF;
    logic [2:0] cmd_len = 3'd3;
    logic       pwm_out, dir_out, tick10, cts;

    int checks = 0;
    int errors = 0;
    bit mon_busy = 1'b0;
    bit done = 1'b0;

    typedef struct {
        int    hi;
        int    lo;
        bit    fwd;
        int    scale;
        string req;
    } exp_t;
    exp_t q[$];

    always #2.5 clk = ~clk;
    always @(posedge clk) tick <= half_rate ? ~tick : 1'b1;

    dccpwm_top #(.PERIOD(P), .FRAME_PERIODS(FP), .ADDR(3), .LEN_W(3),
                 .PWM_ACT_HIGH(1'b1), .DIR_FWD_HIGH(1'b0)) u0 (
        .clk(clk), .rst_n(rst_n), .tick(tick), .track_pwr(track_pwr),
        .cmd_b0(cmd_b0), .cmd_b1(cmd_b1), .cmd_b2(cmd_b2), .cmd_len(cmd_len),
        .pwm_out(pwm_out), .dir_out(dir_out), .tick10(tick10), .cts(cts)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // R6 formula, evaluated with the default period constants
    function automatic int hi_of(input logic [7:0] b1);
        int s, j;
        s = int'(b1[3:0]);
        if (s <= 1) return 0;
        j = s * 2 + int'(b1[4]) - 3;
        if (j > 28) j = 28;
        return 178 + j * 6;
    endfunction

    task automatic wait_sample();
        do @(negedge clk); while (tick10 !== 1'b1);
        @(negedge clk);
        while (mon_busy) @(negedge clk);
    endtask

    task automatic push(input int hi, input bit fwd, input int scale, input string req);
        exp_t e;
        e.hi = hi; e.lo = (hi == 0) ? P : P - hi;
        e.fwd = fwd; e.scale = scale; e.req = req;
        q.push_back(e);
    endtask

    // monitor: at each sample strobe, measure the period that starts there
    initial begin
        forever begin
            @(negedge clk);
            if (tick10 === 1'b1) begin
                check("R4 cts with tick10", int'(cts), 1);
                if (q.size() > 0) begin
                    exp_t e;
                    int hi, lo;
                    mon_busy = 1'b1;
                    e = q.pop_front();
                    check({e.req, " dir (R7/R12)"}, int'(dir_out), e.fwd ? 0 : 1);
                    hi = 0; lo = 0;
                    while (pwm_out === 1'b1) begin hi++; @(negedge clk); end
                    while (pwm_out === 1'b0 && lo < P * e.scale) begin lo++; @(negedge clk); end
                    check({e.req, " high ticks (R10)"}, hi, e.hi * e.scale);
                    check({e.req, " low ticks (R2)"}, lo, e.lo * e.scale);
                    mon_busy = 1'b0;
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual 0 expected 1");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int n;
        logic [7:0] b;
        repeat (3) @(negedge clk);
        check("R1 pwm inactive", int'(pwm_out), 0);
        check("R1 dir reverse", int'(dir_out), 1);
        check("R1 tick10 low", int'(tick10), 0);
        check("R1 cts low", int'(cts), 0);
        rst_n = 1'b1;
        // R1/R3: idle buffer, zero duty, first sample after FP full periods
        n = 0;
        do begin @(negedge clk); n++; check("R3 low while zero duty", int'(pwm_out), 0); end
        while (tick10 !== 1'b1);
        check("R4 first sample time", n, FP * P);
        n = 0;
        do begin @(negedge clk); n++; end while (tick10 !== 1'b1);
        check("R4 sample interval", n, FP * P);
        @(negedge clk);
        check("R4 strobe one cycle", int'(tick10), 0);

        // R6/R7: all speed-byte patterns, both directions
        for (int d = 0; d < 2; d++) begin
            for (int s = 0; s < 16; s++) begin
                for (int c = 0; c < 2; c++) begin
                    b = {2'b01, 1'(d), 1'(c), 4'(s)};
                    wait_sample();
                    cmd_b0 = 8'd3; cmd_b1 = b; cmd_len = 3'd2;
                    push(hi_of(b), bit'(d), 1, "R6 speed");
                end
            end
        end
        // last pattern: 0x7F -> high 346, forward
        wait_sample();
        cmd_b0 = 8'd4; cmd_b1 = 8'h45;
        push(346, 1'b1, 1, "R5 other address");
        wait_sample();
        cmd_b0 = 8'd3; cmd_b1 = 8'h80; cmd_len = 3'd3;
        push(346, 1'b1, 1, "R9 other instruction");
        wait_sample();
        cmd_b1 = 8'h45; cmd_len = 3'd1;
        push(346, 1'b1, 1, "R9 short length");
        wait_sample();
        cmd_b1 = 8'h3F; cmd_b2 = 8'h00; cmd_len = 3'd2;
        push(346, 1'b1, 1, "R8 extended short length");
        wait_sample();
        cmd_len = 3'd3;
        push(346, 1'b0, 1, "R8 extended reverse");
        wait_sample();
        cmd_b2 = 8'h80;
        push(346, 1'b1, 1, "R8 extended forward");
        wait_sample();
        cmd_b1 = 8'h68; cmd_len = 3'd2; track_pwr = 1'b0;
        push(0, 1'b1, 1, "R11 power off");
        wait_sample();
        track_pwr = 1'b1;
        push(hi_of(8'h68), 1'b1, 1, "R11 power restored");
        wait_sample();
        half_rate = 1'b1;
        cmd_b1 = 8'h48;
        push(hi_of(8'h48), 1'b0, 2, "R2 half-rate tick");
        wait_sample();
        wait_sample();
        check("R2 queue drained", q.size(), 0);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule